// File: doc/BRIEF.md
# Byte-Window Memory Access Register File

This block lets a host with only a narrow byte bus reach a word-wide local memory. The host sees eight byte registers. Two are mailboxes, one per direction. Two hold a memory address, and the low two bits of that address pick an access type. Four are data bytes that stand for the four byte lanes of the addressed 32-bit word.

In byte mode each data register reads or writes one memory byte directly. In the 16-bit and 32-bit modes, the data registers are a staging word. Touching particular lanes moves the word to or from memory. In 32-bit modes, a read of lane 0 loads the word and a write of lane 3 stores it. In 16-bit mode, a read of lane 0 or lane 2 loads the word, and a write of lane 1 or lane 3 stores the matching halfword. The auto-increment variant of 32-bit mode advances the word address after each lane-3 access, so a driver can stream a buffer with no address rewrites. Reads that need memory data hold the host with a wait signal until the data is ready.

The local side has its own mailbox strobes. Each mailbox raises a sticky pending flag for the receiving side, and that flag clears when the receiver reads the mailbox.

Top module: `memWindowRegs`

## Requirements
- R1: After reset, every host register reads 0x00, both pending flags are low and hostWait is low.
- R2: Offset 2 holds {word address bits [7:2], mode[1:0]} and reads back as written. Offset 3 holds address bits [14:8] in its bits [6:0]. Its bit 7 is ignored and reads as 0. Mode encoding: 0 byte, 1 halfword, 2 word, 3 word with auto-increment.
- R3: In byte mode (0), a host write to offset 4+N stores that byte into lane N of the addressed word and leaves the other lanes unchanged. A host read of offset 4+N returns lane N from memory.
- R4: In modes 2 and 3, a read of offset 4 loads the whole addressed word into the staging word. Reads of offsets 5 to 7 then return staging lanes 1 to 3 with no wait.
- R5: In modes 2 and 3, writes to offsets 4 to 6 change only the staging word and not memory. A write to offset 7 stores the complete staging word, with lane 3 taken from that write.
- R6: In mode 3, any host read or write of offset 7 advances the word address by one word (byte address +4), and this shows in the offset 2 and 3 readback. In mode 2 the address does not move.
- R7: In mode 1, reads of offsets 4 and 6 load the staging word. A write to offset 5 stores staging lanes 0 and 1, and a write to offset 7 stores lanes 2 and 3. The other lanes of memory are unchanged.
- R8: A host write to offset 0 sets toLocalPending and presents the byte on localMboxRdata. A localMboxRd pulse clears the flag.
- R9: A localMboxWr pulse stores localMboxWdata into the offset 1 mailbox and sets toHostPending. A host read of offset 1 returns the byte and clears the flag.
- R10: A read that needs memory data (a load read, or any data read in byte mode) holds hostWait high for exactly two cycles and then returns the data. All other reads and all writes complete with no wait.
- R11: Auto-increment wraps from the highest word address (offset 3 = 0x7F, offset 2 bits [7:2] all ones) to word address 0.
- R12: A host write to offset 1 is ignored, and the mailbox keeps the byte from the local side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Host register offset 0 to 7 |
| hostWrEn | input | 1 | Host write strobe, one cycle |
| hostRdEn | input | 1 | Host read request, held until hostWait is low |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, valid while hostRdEn is high and hostWait is low |
| hostWait | output | 1 | Stalls a host read until memory data is ready |
| localMboxWr | input | 1 | Local side writes the offset 1 mailbox |
| localMboxWdata | input | 8 | Byte for the offset 1 mailbox |
| localMboxRd | input | 1 | Local side reads the offset 0 mailbox and clears its flag |
| localMboxRdata | output | 8 | Contents of the offset 0 mailbox |
| toLocalPending | output | 1 | Offset 0 mailbox written and not yet read by the local side |
| toHostPending | output | 1 | Offset 1 mailbox written and not yet read by the host |

## Verification
The bench builds the block with MemAddrBits = 8, which gives a 64-word memory. Every word is then addressable through the offset 2 register alone, with offset 3 at zero. The small memory lets the bench fill and read back every byte lane under several modes:
- byte writes checked by word loads;
- auto-increment streaming writes checked by byte reads.

The full 15-bit address register is kept in this build, so the top-of-range wrap of auto-increment and the masking of offset 3 are exercised directly through the readback.

// File: rtl/memWindowPkg.sv
package memWindowPkg;

  typedef enum logic [1:0] {
    ModeByte    = 2'd0,
    ModeHalf    = 2'd1,
    ModeWord    = 2'd2,
    ModeWordInc = 2'd3
  } accessMode_t;

  localparam logic [2:0] RegToLocal = 3'd0;
  localparam logic [2:0] RegToHost  = 3'd1;
  localparam logic [2:0] RegAddrLo  = 3'd2;
  localparam logic [2:0] RegAddrHi  = 3'd3;
  localparam logic [2:0] RegData3   = 3'd7;

  typedef struct packed {
    logic       memRe;
    logic       memWe;
    logic [3:0] memBe;
    logic       stageLoad;
    logic       holdLoad;
    logic       stageWrite;
    logic       addrLoWr;
    logic       addrHiWr;
    logic       addrInc;
    logic       toLocalWr;
    logic       toHostRdClr;
  } ctrlStrobes_t;

endpackage

// File: rtl/windowRam.sv
module windowRam #(
  parameter int IndexBits = 10
) (
  input  logic                 clk,
  input  logic                 re,
  input  logic                 we,
  input  logic [3:0]           be,
  input  logic [IndexBits-1:0] index,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata
);
  localparam int Depth = 1 << IndexBits;

  logic [31:0] store [Depth];

  always_ff @(posedge clk) begin
    if (re) rdata <= store[index];
  end

  for (genvar lane = 0; lane < 4; lane++) begin : gLane
    always_ff @(posedge clk) begin
      if (we && be[lane]) store[index][lane*8 +: 8] <= wdata[lane*8 +: 8];
    end
  end
endmodule

// File: rtl/windowCtrl.sv
module windowCtrl
  import memWindowPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   hostAddr,
  input  logic         hostWrEn,
  input  logic         hostRdEn,
  input  accessMode_t  mode,
  output ctrlStrobes_t strobes,
  output logic         hostWait
);
  typedef enum logic [1:0] {StIdle, StFetch, StDone} ctrlState_t;

  ctrlState_t state, stateNext;

  logic       isData;
  logic [1:0] lane;
  logic       rdReq;
  logic       wrReq;
  logic       wordMode;
  logic       needLoad;
  logic       needByteRd;
  logic       needMem;

  assign isData     = hostAddr[2];
  assign lane       = hostAddr[1:0];
  assign wrReq      = hostWrEn;
  assign rdReq      = hostRdEn & ~hostWrEn;
  assign wordMode   = (mode == ModeWord) || (mode == ModeWordInc);
  assign needLoad   = rdReq && isData &&
                      ((wordMode && lane == 2'd0) || (mode == ModeHalf && !lane[0]));
  assign needByteRd = rdReq && isData && (mode == ModeByte);
  assign needMem    = needLoad || needByteRd;

  always_comb begin
    strobes   = '0;
    hostWait  = 1'b0;
    stateNext = state;
    case (state)
      StIdle: begin
        if (needMem) begin
          strobes.memRe = 1'b1;
          hostWait      = 1'b1;
          stateNext     = StFetch;
        end else begin
          if (wrReq) begin
            case (hostAddr)
              RegToLocal: strobes.toLocalWr = 1'b1;
              RegAddrLo:  strobes.addrLoWr  = 1'b1;
              RegAddrHi:  strobes.addrHiWr  = 1'b1;
              default: begin
                if (isData) begin
                  if (mode == ModeByte) begin
                    strobes.memWe = 1'b1;
                    strobes.memBe = 4'b0001 << lane;
                  end else begin
                    strobes.stageWrite = 1'b1;
                    if (wordMode && lane == 2'd3) begin
                      strobes.memWe = 1'b1;
                      strobes.memBe = 4'b1111;
                    end else if (mode == ModeHalf && lane[0]) begin
                      strobes.memWe = 1'b1;
                      strobes.memBe = lane[1] ? 4'b1100 : 4'b0011;
                    end
                  end
                end
              end
            endcase
          end
          if (rdReq && hostAddr == RegToHost) strobes.toHostRdClr = 1'b1;
          if ((rdReq || wrReq) && mode == ModeWordInc && hostAddr == RegData3)
            strobes.addrInc = 1'b1;
        end
      end
      StFetch: begin
        hostWait = 1'b1;
        if (mode == ModeByte) strobes.holdLoad  = 1'b1;
        else                  strobes.stageLoad = 1'b1;
        stateNext = StDone;
      end
      default: stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= StIdle;
    else       state <= stateNext;
  end

  assert_read_stalls_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memRe |=> hostWait);

  assert_no_rw_clash_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.memRe && strobes.memWe));

  assert_write_no_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && state == StIdle) |-> !hostWait);
endmodule

// File: rtl/windowDatapath.sv
module windowDatapath
  import memWindowPkg::*;
#(
  parameter int AddrBits    = 15,
  parameter int MemAddrBits = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [2:0]             hostAddr,
  input  logic [7:0]             hostWdata,
  output logic [7:0]             hostRdata,
  output accessMode_t            mode,
  input  logic [31:0]            memRdata,
  output logic [MemAddrBits-3:0] memIndex,
  output logic [31:0]            memWdata,
  input  logic                   localMboxWr,
  input  logic [7:0]             localMboxWdata,
  input  logic                   localMboxRd,
  output logic [7:0]             localMboxRdata,
  output logic                   toLocalPending,
  output logic                   toHostPending
);
  localparam int WordBits = AddrBits - 2;
  localparam int HiBits   = AddrBits - 8;

  logic [WordBits-1:0] wordAddr;
  logic [31:0]         stageWord;
  logic [31:0]         holdWord;
  logic [7:0]          toLocalReg;
  logic [7:0]          toHostReg;
  logic [1:0]          lane;
  logic [7:0]          hiRead;
  logic [7:0]          dataByte;

  assign lane           = hostAddr[1:0];
  assign memIndex       = wordAddr[MemAddrBits-3:0];
  assign localMboxRdata = toLocalReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr <= '0;
      mode     <= ModeByte;
    end else if (strobes.addrLoWr) begin
      wordAddr[5:0] <= hostWdata[7:2];
      mode          <= accessMode_t'(hostWdata[1:0]);
    end else if (strobes.addrHiWr) begin
      wordAddr[WordBits-1:6] <= hostWdata[HiBits-1:0];
    end else if (strobes.addrInc) begin
      wordAddr <= wordAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageWord <= '0;
      holdWord  <= '0;
    end else begin
      if (strobes.stageLoad)       stageWord <= memRdata;
      else if (strobes.stageWrite) stageWord[lane*8 +: 8] <= hostWdata;
      if (strobes.holdLoad)        holdWord  <= memRdata;
    end
  end

  always_comb begin
    memWdata = stageWord;
    memWdata[lane*8 +: 8] = hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toLocalReg     <= '0;
      toHostReg      <= '0;
      toLocalPending <= 1'b0;
      toHostPending  <= 1'b0;
    end else begin
      if (strobes.toLocalWr) begin
        toLocalReg     <= hostWdata;
        toLocalPending <= 1'b1;
      end else if (localMboxRd) begin
        toLocalPending <= 1'b0;
      end
      if (localMboxWr) begin
        toHostReg     <= localMboxWdata;
        toHostPending <= 1'b1;
      end else if (strobes.toHostRdClr) begin
        toHostPending <= 1'b0;
      end
    end
  end

  always_comb begin
    hiRead = '0;
    hiRead[HiBits-1:0] = wordAddr[WordBits-1:6];
    dataByte = (mode == ModeByte) ? holdWord[lane*8 +: 8] : stageWord[lane*8 +: 8];
    case (hostAddr)
      RegToLocal: hostRdata = toLocalReg;
      RegToHost:  hostRdata = toHostReg;
      RegAddrLo:  hostRdata = {wordAddr[5:0], mode};
      RegAddrHi:  hostRdata = hiRead;
      default:    hostRdata = dataByte;
    endcase
  end

  assert_inc_one_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addrInc |=> wordAddr == $past(wordAddr) + 1'b1);

  assert_local_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toLocalWr |=> toLocalPending);

  assert_host_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    localMboxWr |=> toHostPending);

  assert_flush_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.memWe && (mode == ModeWord || mode == ModeWordInc))
      |-> (strobes.memBe == 4'hF && hostAddr == RegData3));
endmodule

// File: rtl/memWindowRegs.sv
module memWindowRegs
  import memWindowPkg::*;
#(
  parameter int AddrBits    = 15,
  parameter int MemAddrBits = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       hostWait,
  input  logic       localMboxWr,
  input  logic [7:0] localMboxWdata,
  input  logic       localMboxRd,
  output logic [7:0] localMboxRdata,
  output logic       toLocalPending,
  output logic       toHostPending
);
  localparam int IndexBits = MemAddrBits - 2;

  ctrlStrobes_t         strobes;
  accessMode_t          mode;
  logic [31:0]          memRdata;
  logic [31:0]          memWdata;
  logic [IndexBits-1:0] memIndex;

  windowCtrl uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .mode(mode), .strobes(strobes), .hostWait(hostWait)
  );

  windowDatapath #(.AddrBits(AddrBits), .MemAddrBits(MemAddrBits)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .mode(mode),
    .memRdata(memRdata), .memIndex(memIndex), .memWdata(memWdata),
    .localMboxWr(localMboxWr), .localMboxWdata(localMboxWdata),
    .localMboxRd(localMboxRd), .localMboxRdata(localMboxRdata),
    .toLocalPending(toLocalPending), .toHostPending(toHostPending)
  );

  windowRam #(.IndexBits(IndexBits)) uRam (
    .clk(clk), .re(strobes.memRe), .we(strobes.memWe), .be(strobes.memBe),
    .index(memIndex), .wdata(memWdata), .rdata(memRdata)
  );
endmodule

// File: tb/memWindowRegs_test.sv
module memWindowRegs_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostWrEn = 1'b0;
  logic       hostRdEn = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       hostWait;
  logic       localMboxWr = 1'b0;
  logic [7:0] localMboxWdata = '0;
  logic       localMboxRd = 1'b0;
  logic [7:0] localMboxRdata;
  logic       toLocalPending;
  logic       toHostPending;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  memWindowRegs #(.AddrBits(15), .MemAddrBits(8)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostWait(hostWait), .localMboxWr(localMboxWr),
    .localMboxWdata(localMboxWdata), .localMboxRd(localMboxRd),
    .localMboxRdata(localMboxRdata), .toLocalPending(toLocalPending),
    .toHostPending(toHostPending)
  );

  task automatic checkEq(input string tag, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic hostWrite(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    hostAddr = r; hostWdata = d; hostWrEn = 1'b1;
    @(posedge clk);
    #1 hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] r, output logic [7:0] d, output int waits);
    @(negedge clk);
    hostAddr = r; hostRdEn = 1'b1; waits = 0;
    #1;
    while (hostWait) begin
      waits++;
      @(negedge clk);
      #1;
    end
    d = hostRdata;
    @(posedge clk);
    #1 hostRdEn = 1'b0;
  endtask

  function automatic logic [7:0] patA(input int w, input int ln);
    return 8'((w * 4 + ln) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] patC(input int w, input int ln);
    return 8'(w * 3 + ln * 8'h41 + 8'h11);
  endfunction

  function automatic logic [7:0] lowReg(input int w, input int m);
    return {6'(w), 2'(m)};
  endfunction

  initial begin
    logic [7:0] d;
    int waits;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    #1;
    checkEq("R1 wait", int'(hostWait), 0);
    checkEq("R1 toLocalPending", int'(toLocalPending), 0);
    checkEq("R1 toHostPending", int'(toHostPending), 0);
    for (int r = 0; r < 4; r++) begin
      hostRead(3'(r), d, waits);
      checkEq($sformatf("R1 reg%0d", r), int'(d), 0);
    end

    // R2 address readback and high bit 7 masking
    hostWrite(3'd2, 8'hB6);
    hostRead(3'd2, d, waits);
    checkEq("R2 low readback", int'(d), 8'hB6);
    hostWrite(3'd3, 8'h85);
    hostRead(3'd3, d, waits);
    checkEq("R2 high bit7 ignored", int'(d), 8'h05);
    hostWrite(3'd3, 8'h00);

    // R3 byte-mode fill of every lane of every word
    for (int w = 0; w < 64; w++) begin
      hostWrite(3'd2, lowReg(w, 0));
      for (int ln = 0; ln < 4; ln++) hostWrite(3'(4 + ln), patA(w, ln));
    end
    // R4 word loads check the fill
    for (int w = 0; w < 64; w++) begin
      hostWrite(3'd2, lowReg(w, 2));
      hostRead(3'd4, d, waits);
      checkEq($sformatf("R4 load w%0d lane0", w), int'(d), int'(patA(w, 0)));
      if (w == 0) checkEq("R10 load waits", waits, 2);
      for (int ln = 1; ln < 4; ln++) begin
        hostRead(3'(4 + ln), d, waits);
        checkEq($sformatf("R4 w%0d lane%0d", w, ln), int'(d), int'(patA(w, ln)));
        if (w == 0 && ln == 1) checkEq("R10 staged read no wait", waits, 0);
      end
    end

    // R6 auto-increment streaming write of the whole memory
    hostWrite(3'd2, lowReg(0, 3));
    for (int w = 0; w < 64; w++)
      for (int ln = 0; ln < 4; ln++) hostWrite(3'(4 + ln), patC(w, ln));
    hostRead(3'd2, d, waits);
    checkEq("R6 low after 64 incs", int'(d), 8'h03);
    hostRead(3'd3, d, waits);
    checkEq("R6 high after 64 incs", int'(d), 8'h01);
    hostWrite(3'd3, 8'h00);

    // R3 byte-mode readback of the streamed data
    for (int w = 0; w < 64; w++) begin
      hostWrite(3'd2, lowReg(w, 0));
      for (int ln = 0; ln < 4; ln++) begin
        hostRead(3'(4 + ln), d, waits);
        checkEq($sformatf("R3 w%0d lane%0d", w, ln), int'(d), int'(patC(w, ln)));
        if (w == 0 && ln == 2) checkEq("R10 byte read waits", waits, 2);
      end
    end

    // R5 lanes 0..2 do not reach memory until lane 3 is written
    hostWrite(3'd2, lowReg(5, 2));
    hostRead(3'd4, d, waits);
    hostWrite(3'd4, 8'hE0);
    hostWrite(3'd5, 8'hE1);
    hostWrite(3'd6, 8'hE2);
    hostWrite(3'd2, lowReg(5, 0));
    for (int ln = 0; ln < 4; ln++) begin
      hostRead(3'(4 + ln), d, waits);
      checkEq($sformatf("R5 before flush lane%0d", ln), int'(d), int'(patC(5, ln)));
    end
    hostWrite(3'd2, lowReg(5, 2));
    hostWrite(3'd7, 8'hE3);
    hostWrite(3'd2, lowReg(5, 0));
    for (int ln = 0; ln < 4; ln++) begin
      hostRead(3'(4 + ln), d, waits);
      checkEq($sformatf("R5 after flush lane%0d", ln), int'(d), 8'hE0 + ln);
    end

    // R7 halfword stores
    hostWrite(3'd2, lowReg(9, 1));
    hostRead(3'd4, d, waits);
    checkEq("R7 load lane0", int'(d), int'(patC(9, 0)));
    hostWrite(3'd4, 8'hA1);
    hostWrite(3'd5, 8'hA2);
    hostWrite(3'd2, lowReg(9, 0));
    hostRead(3'd4, d, waits); checkEq("R7 low half lane0", int'(d), 8'hA1);
    hostRead(3'd5, d, waits); checkEq("R7 low half lane1", int'(d), 8'hA2);
    hostRead(3'd6, d, waits); checkEq("R7 lane2 kept", int'(d), int'(patC(9, 2)));
    hostRead(3'd7, d, waits); checkEq("R7 lane3 kept", int'(d), int'(patC(9, 3)));
    hostWrite(3'd2, lowReg(9, 1));
    hostRead(3'd6, d, waits);
    checkEq("R7 load lane2", int'(d), int'(patC(9, 2)));
    checkEq("R10 half load waits", waits, 2);
    hostRead(3'd5, d, waits);
    checkEq("R7 reloaded lane1", int'(d), 8'hA2);
    checkEq("R10 half staged no wait", waits, 0);
    hostWrite(3'd6, 8'hB3);
    hostWrite(3'd7, 8'hB4);
    hostWrite(3'd2, lowReg(9, 0));
    hostRead(3'd4, d, waits); checkEq("R7 lane0 kept", int'(d), 8'hA1);
    hostRead(3'd6, d, waits); checkEq("R7 high half lane2", int'(d), 8'hB3);
    hostRead(3'd7, d, waits); checkEq("R7 high half lane3", int'(d), 8'hB4);

    // R6 mode 2 does not advance the address
    hostWrite(3'd2, lowReg(3, 2));
    hostRead(3'd7, d, waits);
    hostWrite(3'd7, 8'h77);
    hostRead(3'd2, d, waits);
    checkEq("R6 mode2 no increment", int'(d), int'(lowReg(3, 2)));
    // R6 mode 3 read of lane 3 advances
    hostWrite(3'd2, lowReg(3, 3));
    hostRead(3'd7, d, waits);
    hostRead(3'd2, d, waits);
    checkEq("R6 mode3 read increments", int'(d), int'(lowReg(4, 3)));

    // R11 wrap at the top of the address range
    hostWrite(3'd3, 8'h7F);
    hostWrite(3'd2, 8'hFF);
    hostWrite(3'd7, 8'h00);
    hostRead(3'd2, d, waits);
    checkEq("R11 wrap low", int'(d), 8'h03);
    hostRead(3'd3, d, waits);
    checkEq("R11 wrap high", int'(d), 8'h00);

    // R8 host-to-local mailbox
    hostWrite(3'd0, 8'h3C);
    #1;
    checkEq("R8 pending set", int'(toLocalPending), 1);
    checkEq("R8 local data", int'(localMboxRdata), 8'h3C);
    @(negedge clk); localMboxRd = 1'b1;
    @(posedge clk); #1 localMboxRd = 1'b0;
    checkEq("R8 pending cleared", int'(toLocalPending), 0);

    // R9 local-to-host mailbox, R12 host write ignored
    @(negedge clk); localMboxWdata = 8'hC3; localMboxWr = 1'b1;
    @(posedge clk); #1 localMboxWr = 1'b0;
    checkEq("R9 pending set", int'(toHostPending), 1);
    hostWrite(3'd1, 8'hFF);
    checkEq("R12 pending unchanged", int'(toHostPending), 1);
    hostRead(3'd1, d, waits);
    checkEq("R12 mailbox kept", int'(d), 8'hC3);
    #1;
    checkEq("R9 pending cleared", int'(toHostPending), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule